// File: doc/BRIEF.md
# Masked Packed-Vector Lane Writeback

This block forms the destination value of a packed vector operation on 64-bit elements, up to 512 bits wide. Each lane is independently computed from the first source and the second operand, kept at its old destination value, or cleared, depending on a per-lane writemask and a merge/zero flag. The second operand is either a full vector or, for memory operands with the broadcast bit set, one 64-bit value replicated to every lane.

The per-lane arithmetic is done by an instantiated lane operator. In this build that operator is a 64-bit integer adder, which keeps the writeback logic testable on its own. The block also selects the rounding mode meant for the operator: either a per-instruction field or the global rounding setting. The rounding mode is presented on an output, registered together with the result. Bits above the active vector length are cleared or preserved depending on the encoding class.

All of the selection logic is combinational. A single register stage follows it, so a result appears one cycle after its input was marked valid.

Top module: `vec_lane_writeback`

## Requirements
- R1: Lane j occupies bits [64j+63:64j]. `vlSel` selects the active vector length: 0 gives 2 lanes (128 bits), 1 gives 4 lanes (256 bits), and 2 or 3 give 8 lanes (512 bits). A computed lane holds `src1` lane j plus the second operand lane, modulo 2^64.
- R2: For `encClass` = 2 (masked class) with `maskEn` = 1, an active lane j is computed only when `mask[j]` = 1.
- R3: In the masked class with `maskEn` = 1, `mask[j]` = 0 and `zeroMode` = 0, active lane j takes `oldDest` lane j.
- R4: In the masked class with `maskEn` = 1, `mask[j]` = 0 and `zeroMode` = 1, active lane j is all zeros.
- R5: With `maskEn` = 0, or with `encClass` = 1 or 3 (unmasked classes), every active lane is computed and `mask` and `zeroMode` have no effect.
- R6: In the masked class, when `src2IsMem` = 1 and `bcastBit` = 1, every lane uses `src2[63:0]` as its second operand. In every other case lane j uses `src2` lane j.
- R7: For `encClass` 1, 2 and 3, all result bits above the active vector length are zero.
- R8: For `encClass` = 0 (legacy class), the vector length is 128 bits whatever `vlSel` holds. Lanes 0 and 1 are `src1` + `src2`, the mask, zero flag and broadcast have no effect, and bits [511:128] equal `oldDest[511:128]`.
- R9: Mask bits of lanes at or beyond the active lane count have no effect on the result.
- R10: `rndMode` equals `instRc` when `encClass` = 2, `vlSel` selects 512 bits, `src2IsMem` = 0 and `bcastBit` = 1. Otherwise it equals `globalRc`.
- R11: `outValid` is `inValid` delayed by one cycle. `result` and `rndMode` update only on a cycle with `inValid` = 1 and hold otherwise. Reset clears `outValid`, `result` and `rndMode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Inputs carry an operation this cycle |
| src1 | input | 512 | First source vector |
| src2 | input | 512 | Second source vector or memory operand |
| src2IsMem | input | 1 | Second operand comes from memory |
| bcastBit | input | 1 | Broadcast (memory) or static-rounding (register) bit |
| maskEn | input | 1 | A writemask is in use |
| mask | input | 8 | Per-lane writemask |
| zeroMode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| vlSel | input | 2 | Vector length select |
| encClass | input | 2 | Encoding class: 0 legacy, 1/3 unmasked, 2 masked |
| oldDest | input | 512 | Previous destination contents |
| instRc | input | 2 | Per-instruction rounding field |
| globalRc | input | 2 | Global rounding setting |
| outValid | output | 1 | Result valid |
| result | output | 512 | Assembled destination value |
| rndMode | output | 2 | Rounding mode chosen for the lane operator |

## Verification
The case that is hardest to reach from the ports is a masked-class operation with a short vector length whose mask has bits set above the active lanes, combined with broadcast or zeroing. Only that combination shows whether stray mask bits leak into the cleared upper region. The bench sweeps every combination of vector length, class, merge/zero, memory and broadcast flags and mask enable, using a random mask in each. It then adds random vectors with saturated masks (all ones, or ones only above the active lanes) and a directed rounding-select case at 512 bits with a register operand.

// File: rtl/vwb_pkg.sv
package vwb_pkg;
  localparam int LANE_W    = 64;
  localparam int MAX_LANES = 8;
  localparam int VEC_W     = LANE_W * MAX_LANES;

  typedef enum logic [1:0] {
    CLS_LEGACY = 2'd0,
    CLS_PLAIN  = 2'd1,
    CLS_MASKED = 2'd2,
    CLS_SPARE  = 2'd3
  } encClass_e;

  // Strobes from control to datapath. A lane with neither laneSum nor laneOld is cleared.
  typedef struct packed {
    logic [MAX_LANES-1:0] laneSum;
    logic [MAX_LANES-1:0] laneOld;
    logic                 bcast;
    logic                 useInstRc;
  } wbCtrl_t;
endpackage

// File: rtl/vwb_lane_op.sv
module vwb_lane_op #(
  parameter int W = 64
) (
  input  logic [W-1:0] opA,
  input  logic [W-1:0] opB,
  output logic [W-1:0] opSum
);
  assign opSum = opA + opB;
endmodule

// File: rtl/vwb_ctrl.sv
module vwb_ctrl
  import vwb_pkg::*;
#(
  parameter int LANES = MAX_LANES
) (
  input  logic [1:0]       vlSel,
  input  logic [1:0]       encClass,
  input  logic             maskEn,
  input  logic [LANES-1:0] mask,
  input  logic             zeroMode,
  input  logic             src2IsMem,
  input  logic             bcastBit,
  output wbCtrl_t          ctrl
);
  localparam int LCW = $clog2(LANES + 1);

  logic             isLegacy;
  logic             isMasked;
  logic [LCW-1:0]   laneCount;
  logic [LANES-1:0] inRange;
  logic [LANES-1:0] laneOn;

  assign isLegacy = (encClass == CLS_LEGACY);
  assign isMasked = (encClass == CLS_MASKED);

  always_comb begin
    if (isLegacy) begin
      laneCount = LCW'(LANES / 4);
    end else begin
      case (vlSel)
        2'd0:    laneCount = LCW'(LANES / 4);
        2'd1:    laneCount = LCW'(LANES / 2);
        default: laneCount = LCW'(LANES);
      endcase
    end
  end

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign inRange[j]      = (LCW'(j) < laneCount);
    assign laneOn[j]       = (isMasked && maskEn) ? mask[j] : 1'b1;
    assign ctrl.laneSum[j] = inRange[j] && laneOn[j];
    assign ctrl.laneOld[j] = inRange[j] ? (!laneOn[j] && !zeroMode) : isLegacy;
  end

  assign ctrl.bcast     = isMasked && src2IsMem && bcastBit;
  assign ctrl.useInstRc = isMasked && vlSel[1] && !src2IsMem && bcastBit;
endmodule

// File: rtl/vwb_datapath.sv
module vwb_datapath
  import vwb_pkg::*;
#(
  parameter int LANES = MAX_LANES,
  parameter int LW    = LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [LANES*LW-1:0] src1,
  input  logic [LANES*LW-1:0] src2,
  input  logic [LANES*LW-1:0] oldDest,
  input  wbCtrl_t             ctrl,
  input  logic [1:0]          instRc,
  input  logic [1:0]          globalRc,
  output logic                outValid,
  output logic [LANES*LW-1:0] result,
  output logic [1:0]          rndMode
);
  localparam int VW = LANES * LW;

  logic [VW-1:0] nextRes;
  logic [1:0]    nextRc;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [LW-1:0] opB;
    logic [LW-1:0] laneSum;
    assign opB = ctrl.bcast ? src2[LW-1:0] : src2[j*LW +: LW];
    vwb_lane_op #(.W(LW)) u_op (
      .opA  (src1[j*LW +: LW]),
      .opB  (opB),
      .opSum(laneSum)
    );
    assign nextRes[j*LW +: LW] = ctrl.laneSum[j] ? laneSum :
                                 ctrl.laneOld[j] ? oldDest[j*LW +: LW] : '0;
  end

  assign nextRc = ctrl.useInstRc ? instRc : globalRc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      rndMode  <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        result  <= nextRes;
        rndMode <= nextRc;
      end
    end
  end
endmodule

// File: rtl/vec_lane_writeback.sv
module vec_lane_writeback
  import vwb_pkg::*;
#(
  parameter int LANES = MAX_LANES,
  parameter int LW    = LANE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [LANES*LW-1:0] src1,
  input  logic [LANES*LW-1:0] src2,
  input  logic                src2IsMem,
  input  logic                bcastBit,
  input  logic                maskEn,
  input  logic [LANES-1:0]    mask,
  input  logic                zeroMode,
  input  logic [1:0]          vlSel,
  input  logic [1:0]          encClass,
  input  logic [LANES*LW-1:0] oldDest,
  input  logic [1:0]          instRc,
  input  logic [1:0]          globalRc,
  output logic                outValid,
  output logic [LANES*LW-1:0] result,
  output logic [1:0]          rndMode
);
  wbCtrl_t ctrl;

  vwb_ctrl #(.LANES(LANES)) u_ctrl (
    .vlSel    (vlSel),
    .encClass (encClass),
    .maskEn   (maskEn),
    .mask     (mask),
    .zeroMode (zeroMode),
    .src2IsMem(src2IsMem),
    .bcastBit (bcastBit),
    .ctrl     (ctrl)
  );

  vwb_datapath #(.LANES(LANES), .LW(LW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .src1    (src1),
    .src2    (src2),
    .oldDest (oldDest),
    .ctrl    (ctrl),
    .instRc  (instRc),
    .globalRc(globalRc),
    .outValid(outValid),
    .result  (result),
    .rndMode (rndMode)
  );
endmodule

// File: rtl/vwb_checker.sv
module vwb_checker (
  input logic         clk,
  input logic         rstN,
  input logic         inValid,
  input logic [1:0]   encClass,
  input logic [1:0]   vlSel,
  input logic         maskEn,
  input logic [1:0]   maskLo,
  input logic         zeroMode,
  input logic         src2IsMem,
  input logic         bcastBit,
  input logic [1:0]   instRc,
  input logic [1:0]   globalRc,
  input logic [511:0] oldDest,
  input logic         outValid,
  input logic [511:0] result,
  input logic [1:0]   rndMode
);
  logic mskOn;
  assign mskOn = (encClass == 2'd2) && maskEn;

  p_valid_rise_r11: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  p_valid_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(rndMode)));

  p_merge_lane0_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mskOn && !zeroMode && !maskLo[0]) |=> result[63:0] == $past(oldDest[63:0]));
  p_merge_lane1_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mskOn && !zeroMode && !maskLo[1]) |=> result[127:64] == $past(oldDest[127:64]));
  p_zero_lane0_r4: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && mskOn && zeroMode && !maskLo[0]) |=> result[63:0] == 64'd0);

  p_upper_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encClass != 2'd0 && vlSel == 2'd0) |=> result[511:128] == '0);
  p_legacy_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encClass == 2'd0) |=> result[511:128] == $past(oldDest[511:128]));

  p_inst_rc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encClass == 2'd2 && vlSel[1] && !src2IsMem && bcastBit)
      |=> rndMode == $past(instRc));
  p_glob_rc_r10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && encClass != 2'd2) |=> rndMode == $past(globalRc));
endmodule

bind vec_lane_writeback vwb_checker chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .encClass (encClass),
  .vlSel    (vlSel),
  .maskEn   (maskEn),
  .maskLo   (mask[1:0]),
  .zeroMode (zeroMode),
  .src2IsMem(src2IsMem),
  .bcastBit (bcastBit),
  .instRc   (instRc),
  .globalRc (globalRc),
  .oldDest  (oldDest),
  .outValid (outValid),
  .result   (result),
  .rndMode  (rndMode)
);

// File: tb/vec_lane_writeback_tb_top.sv
`timescale 1ns/1ps
module vec_lane_writeback_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [511:0] src1 = '0, src2 = '0, oldDest = '0;
  logic         src2IsMem = 1'b0, bcastBit = 1'b0, maskEn = 1'b0, zeroMode = 1'b0;
  logic [7:0]   mask = '0;
  logic [1:0]   vlSel = '0, encClass = '0, instRc = '0, globalRc = '0;
  logic         outValid;
  logic [511:0] result;
  logic [1:0]   rndMode;

  int checks = 0;
  int fails  = 0;
  logic [511:0] lastExp = '0;
  logic [1:0]   lastRc = '0;

  always #10 clk = ~clk;

  vec_lane_writeback dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .src1(src1), .src2(src2),
    .src2IsMem(src2IsMem), .bcastBit(bcastBit), .maskEn(maskEn), .mask(mask),
    .zeroMode(zeroMode), .vlSel(vlSel), .encClass(encClass), .oldDest(oldDest),
    .instRc(instRc), .globalRc(globalRc), .outValid(outValid), .result(result),
    .rndMode(rndMode)
  );

  function automatic logic [511:0] rnd512();
    logic [511:0] v;
    for (int k = 0; k < 16; k++) v[k*32 +: 32] = $urandom;
    return v;
  endfunction

  task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one operation, wait one clock, compare every lane and the rounding mode.
  task automatic applyVec();
    int lanes;
    logic useMask, bc, on;
    logic [63:0] expLane, opB;
    string tag;
    @(negedge clk);
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    lanes   = (encClass == 2'd0 || vlSel == 2'd0) ? 2 : (vlSel == 2'd1) ? 4 : 8;
    useMask = (encClass == 2'd2) && maskEn;
    bc      = (encClass == 2'd2) && src2IsMem && bcastBit;
    check("R11 outValid", {511'd0, outValid}, {511'd0, 1'b1});
    for (int j = 0; j < 8; j++) begin
      if (j < lanes) begin
        on = useMask ? mask[j] : 1'b1;
        if (on) begin
          opB = bc ? src2[63:0] : src2[j*64 +: 64];
          expLane = src1[j*64 +: 64] + opB;
          tag = bc ? "R1/R6 bcast lane" : useMask ? "R1/R2 masked lane" :
                (encClass == 2'd0) ? "R1/R8 legacy lane" : "R1/R5 unmasked lane";
        end else if (zeroMode) begin
          expLane = '0; tag = "R4 zeroed lane";
        end else begin
          expLane = oldDest[j*64 +: 64]; tag = "R3 merged lane";
        end
      end else if (encClass == 2'd0) begin
        expLane = oldDest[j*64 +: 64]; tag = "R8 legacy upper";
      end else begin
        expLane = '0;
        tag = (useMask && mask[j]) ? "R9 stray mask bit" : "R7 upper clear";
      end
      lastExp[j*64 +: 64] = expLane;
      check($sformatf("%s j=%0d", tag, j), {448'd0, result[j*64 +: 64]}, {448'd0, expLane});
    end
    lastRc = ((encClass == 2'd2) && vlSel[1] && !src2IsMem && bcastBit) ? instRc : globalRc;
    check("R10 rounding", {510'd0, rndMode}, {510'd0, lastRc});
  endtask

  task automatic randFields();
    src1 = rnd512(); src2 = rnd512(); oldDest = rnd512();
    instRc = 2'($urandom); globalRc = 2'($urandom);
  endtask

  initial begin : watchdog
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 reset result", result, '0);
    check("R11 reset outValid", {511'd0, outValid}, '0);
    @(negedge clk);
    rstN = 1'b1;

    // Full sweep of the control space, random data and mask.
    for (int vl = 0; vl < 4; vl++)
      for (int cls = 0; cls < 4; cls++)
        for (int f = 0; f < 16; f++) begin
          randFields();
          vlSel = 2'(vl); encClass = 2'(cls);
          {zeroMode, src2IsMem, bcastBit, maskEn} = 4'(f);
          mask = 8'($urandom);
          applyVec();
        end

    // R9: masks that are all ones, or ones only above the active lanes.
    for (int n = 0; n < 40; n++) begin
      randFields();
      vlSel = 2'(n % 2); encClass = 2'd2; maskEn = 1'b1;
      zeroMode = n[2]; src2IsMem = n[3]; bcastBit = n[4];
      mask = (n % 3 == 0) ? 8'hFF : (vlSel == 2'd0 ? 8'hFC : 8'hF0);
      applyVec();
    end

    // R10: directed static-rounding case at 512 bits with a register operand.
    randFields();
    vlSel = 2'd2; encClass = 2'd2; src2IsMem = 1'b0; bcastBit = 1'b1;
    instRc = 2'd3; globalRc = 2'd0; maskEn = 1'b0;
    applyVec();

    // R6: broadcast with all-ones src2 low lane, checks wrap-around.
    randFields();
    vlSel = 2'd3; encClass = 2'd2; src2IsMem = 1'b1; bcastBit = 1'b1;
    maskEn = 1'b0; src2[63:0] = '1;
    applyVec();

    // Random mix with hold checks.
    for (int n = 0; n < 1500; n++) begin
      randFields();
      vlSel = 2'($urandom); encClass = 2'($urandom);
      {zeroMode, src2IsMem, bcastBit, maskEn} = 4'($urandom);
      mask = 8'($urandom);
      applyVec();
      if (n % 50 == 0) begin
        // R11: no valid, changed inputs, outputs hold.
        randFields();
        @(negedge clk);
        check("R11 hold result", result, lastExp);
        check("R11 hold rounding", {510'd0, rndMode}, {510'd0, lastRc});
        check("R11 outValid low", {511'd0, outValid}, '0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule